// File: doc/BRIEF.md
# UART Receive Queue with DMA Request Logic

This block sits between a UART bit deserializer and a DMA engine. Each received character arrives as a one-cycle strobe with its data byte and line-error flags. The block stores the character in a 16-entry queue and produces two kinds of DMA requests from the queue level: a single request and a burst request. Software or the DMA engine removes entries through a shared pop port. Each entry is 11 bits wide and keeps its error flags, so the reader can tell which byte was damaged.

A timer counts baud-times-16 tick pulses. It reports a receive timeout when data has sat in the queue with no traffic for 32 bit periods, or for 64 bit periods in fast mode. This lets software collect the tail of a message that never reaches the trigger level. An interrupt unit holds raw status bits. Most of them are sticky and are cleared by writing 1. The unit forms a masked view and a single interrupt line. While the DMA engine owns the receive channel, the level and timeout causes are kept out of the line. Error and transfer-complete causes still reach it. When the stop-on-error option is set, a line error halts DMA requests until software clears that error. A down-counter reports how many items of the programmed transfer are still outstanding.

Top module: `uart_rx_dma_fifo`

## Requirements
- R1: The queue holds up to 16 entries in first-in first-out order. `rd_data[7:0]` is the oldest byte, bit 8 its framing flag, bit 9 its parity flag, bit 10 its break flag. `level` gives the occupancy, and a pop on an empty queue has no effect.
- R2: A character that arrives while the queue is full, with no pop in the same cycle, is discarded. It sets overrun status `irq_raw[4]`, and the stored contents stay unchanged.
- R3: With the queue not empty and no push or pop, `irq_raw[1]` sets after 512 tick pulses (32 bit periods) when `cfg_fast` is 0, and after 1024 tick pulses when `cfg_fast` is 1.
- R4: `irq_raw[1]` clears on the pop that empties the queue, or on a write of 1 to `irq_clr[1]`. The window restarts on every push and every pop.
- R5: `cfg_trig` selects the trigger level: 0 gives 2, 1 gives 4, 2 gives 8 (half full), 3 gives 12. `irq_raw[0]` is 1 exactly while `level` is at or above that trigger.
- R6: `dma_sreq` is high while the queue is not empty. `dma_breq` is high while `level` is at or above the trigger. Both are low whenever `dma_en` is 0.
- R7: Status bits 1 to 5 are sticky and clear when the matching `irq_clr` bit is 1. A set in the same cycle wins. Bit 2 is framing, bit 3 parity, bit 4 overrun, bit 5 transfer done.
- R8: `irq_masked = irq_raw & irq_mask`, except that bits 0 and 1 are forced to 0 while `dma_en` is 1. Those bits still appear in `irq_raw`. `irq` is the OR of `irq_masked`.
- R9: A framing or parity error sets its raw bit and, when unmasked, drives `irq` even while `dma_en` is 1.
- R10: A `dma_done` pulse sets `irq_raw[5]`, which raises `irq` when `irq_mask[5]` is 1.
- R11: With `dma_on_err` set, any of raw bits 2, 3 or 4 forces both DMA requests low. Requests resume once those bits are cleared.
- R12: `dma_len_load` loads `dma_remaining` from `dma_len`. Each `dma_pop` on a non-empty queue lowers it by one, and it holds at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Character strobe from the deserializer |
| rx_data | input | 8 | Received byte |
| rx_frame_err | input | 1 | Framing error for this character |
| rx_parity_err | input | 1 | Parity error for this character |
| rx_break | input | 1 | Break detected for this character |
| tick16 | input | 1 | Baud-times-16 enable pulse |
| rd_en | input | 1 | Software pop |
| rd_data | output | 11 | Oldest entry {break, parity, framing, byte} |
| level | output | 5 | Queue occupancy |
| cfg_trig | input | 2 | Trigger level select |
| cfg_fast | input | 1 | Doubles the timeout window |
| dma_en | input | 1 | Receive DMA enable |
| dma_on_err | input | 1 | Stop DMA requests on a line error |
| dma_pop | input | 1 | DMA engine pop |
| dma_done | input | 1 | Transfer-complete pulse from DMA engine |
| dma_len_load | input | 1 | Load the transfer count |
| dma_len | input | 16 | Transfer count to load |
| dma_remaining | output | 16 | Items still to transfer |
| dma_sreq | output | 1 | Single request |
| dma_breq | output | 1 | Burst request |
| irq_mask | input | 6 | Interrupt enables |
| irq_clr | input | 6 | Write-one-to-clear pulses |
| irq_raw | output | 6 | Raw status |
| irq_masked | output | 6 | Masked status |
| irq | output | 1 | Interrupt line |

## Verification
The queue is tested with a short mixed-flag sequence, which shows that the flags are stored per entry and that order is kept. It is also filled past capacity, which separates a dropped character from an overwritten one. Each trigger code is exercised one byte below and at its level, so an off-by-one comparison is caught. The timeout is probed well before and just after both window lengths. This tells the normal window from the fast one and shows the clear on drain and the clear on write. The DMA cases switch ownership, inject errors and pulse completion. They show which causes are held back from the line and when requests stop and resume.

// File: rtl/uart_rx_dma_fifo.sv
module uart_rx_dma_fifo #(
  parameter int DEPTH        = 16,
  parameter int TICKS_PER_BIT = 16,
  parameter int TO_BITS      = 32,
  parameter int TO_BITS_FAST = 64,
  parameter int CNT_W        = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_frame_err,
  input  logic              rx_parity_err,
  input  logic              rx_break,
  input  logic              tick16,
  input  logic              rd_en,
  output logic [10:0]       rd_data,
  output logic [$clog2(DEPTH):0] level,
  input  logic [1:0]        cfg_trig,
  input  logic              cfg_fast,
  input  logic              dma_en,
  input  logic              dma_on_err,
  input  logic              dma_pop,
  input  logic              dma_done,
  input  logic              dma_len_load,
  input  logic [CNT_W-1:0]  dma_len,
  output logic [CNT_W-1:0]  dma_remaining,
  output logic              dma_sreq,
  output logic              dma_breq,
  input  logic [5:0]        irq_mask,
  input  logic [5:0]        irq_clr,
  output logic [5:0]        irq_raw,
  output logic [5:0]        irq_masked,
  output logic              irq
);
  localparam int AW     = $clog2(DEPTH);
  localparam int LW     = AW + 1;
  localparam int TO_N   = TO_BITS * TICKS_PER_BIT;
  localparam int TO_F   = TO_BITS_FAST * TICKS_PER_BIT;
  localparam int TOW    = $clog2(TO_F + 1);

  logic [10:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          empty, full, pop, push, ovr, drain, to_hit, hold, at_trig;
  logic [LW-1:0] trig;
  logic [TOW-1:0] to_cnt, to_lim;
  logic [5:1]    sticky;
  logic [5:1]    set_v;

  assign empty = (level == '0);
  assign full  = (level == LW'(DEPTH));
  assign pop   = (rd_en | dma_pop) & ~empty;
  assign push  = rx_valid & (~full | pop);
  assign ovr   = rx_valid & full & ~pop;
  assign drain = pop & ~push & (level == LW'(1));
  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= {rx_break, rx_parity_err, rx_frame_err, rx_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      level <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      if (push && !pop) level <= level + 1'b1;
      else if (pop && !push) level <= level - 1'b1;
    end
  end

  always_comb begin
    case (cfg_trig)
      2'd0:    trig = LW'(DEPTH / 8);
      2'd1:    trig = LW'(DEPTH / 4);
      2'd2:    trig = LW'(DEPTH / 2);
      default: trig = LW'((3 * DEPTH) / 4);
    endcase
  end
  assign at_trig = (level >= trig);

  assign to_lim = cfg_fast ? TOW'(TO_F) : TOW'(TO_N);
  assign to_hit = tick16 & ~empty & ~push & ~pop & (to_cnt == to_lim - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) to_cnt <= '0;
    else if (push || pop) to_cnt <= '0;
    else if (tick16 && !empty && to_cnt < to_lim) to_cnt <= to_cnt + 1'b1;
  end

  assign set_v = {dma_done, ovr, rx_valid & rx_parity_err, rx_valid & rx_frame_err, to_hit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky <= '0;
    else begin
      sticky <= (sticky & ~irq_clr[5:1]) | set_v;
      if (drain && !to_hit) sticky[1] <= 1'b0;
    end
  end

  assign irq_raw    = {sticky, at_trig};
  assign irq_masked = irq_raw & irq_mask & ~(dma_en ? 6'b000011 : 6'b000000);
  assign irq        = |irq_masked;

  assign hold     = dma_on_err & (|sticky[4:2]);
  assign dma_sreq = dma_en & ~hold & ~empty;
  assign dma_breq = dma_en & ~hold & at_trig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dma_remaining <= '0;
    else if (dma_len_load) dma_remaining <= dma_len;
    else if (dma_pop && !empty && dma_remaining != '0) dma_remaining <= dma_remaining - 1'b1;
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH)); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && full && !rd_en && !dma_pop) |=> (full && irq_raw[4])); // R2
  AST_TO_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (level == LW'(1) && pop && !rx_valid) |=> !irq_raw[1]); // R4
  AST_REQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |-> (!dma_sreq && !dma_breq)); // R6
  AST_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
    dma_en |-> (irq_masked[1:0] == 2'b00)); // R8
  AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done |=> irq_raw[5]); // R10
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_on_err && |irq_raw[4:2]) |-> (!dma_sreq && !dma_breq)); // R11
  AST_REM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_pop && !empty && !dma_len_load && dma_remaining != '0)
      |=> (dma_remaining == $past(dma_remaining) - 1'b1)); // R12
endmodule

// File: tb/test_uart_rx_dma_fifo.sv
module test_uart_rx_dma_fifo;
  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, fe = 0, pe = 0, brk = 0, tick16 = 0, rd_en = 0;
  logic [7:0] rx_data = 0;
  logic [10:0] rd_data;
  logic [4:0] level;
  logic [1:0] cfg_trig = 1;
  logic cfg_fast = 0, dma_en = 0, dma_on_err = 0, dma_pop = 0, dma_done = 0, dma_len_load = 0;
  logic [15:0] dma_len = 0, dma_remaining;
  logic dma_sreq, dma_breq, irq;
  logic [5:0] irq_mask = 6'h3f, irq_clr = 0, irq_raw, irq_masked;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_rx_dma_fifo i_uart_rx_dma_fifo (
    .clk, .rst_n, .rx_valid, .rx_data, .rx_frame_err(fe), .rx_parity_err(pe),
    .rx_break(brk), .tick16, .rd_en, .rd_data, .level, .cfg_trig, .cfg_fast,
    .dma_en, .dma_on_err, .dma_pop, .dma_done, .dma_len_load, .dma_len,
    .dma_remaining, .dma_sreq, .dma_breq, .irq_mask, .irq_clr, .irq_raw,
    .irq_masked, .irq);

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic f = 0, input logic p = 0, input logic b = 0);
    @(negedge clk); rx_valid = 1; rx_data = d; fe = f; pe = p; brk = b;
    @(negedge clk); rx_valid = 0; fe = 0; pe = 0; brk = 0;
  endtask

  task automatic pop_sw();
    @(negedge clk); rd_en = 1;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic pop_dma();
    @(negedge clk); dma_pop = 1;
    @(negedge clk); dma_pop = 0;
  endtask

  task automatic clr(input logic [5:0] v);
    @(negedge clk); irq_clr = v;
    @(negedge clk); irq_clr = 0;
  endtask

  task automatic drain_all();
    while (level != 0) pop_sw();
    clr(6'h3e);
  endtask

  task automatic t_reset();
    chk("R1", level, 0, "level after reset");
    chk("R7", irq_raw, 0, "raw after reset");
    chk("R6", {dma_sreq, dma_breq}, 0, "requests after reset");
    chk("R12", dma_remaining, 0, "remaining after reset");
  endtask

  task automatic t_order();
    push(8'hA5, 1, 0, 0);
    push(8'h3C, 0, 1, 0);
    push(8'h7E, 0, 0, 1);
    chk("R1", level, 3, "level after three pushes");
    chk("R1", rd_data, 11'h1A5, "first entry");
    pop_sw();
    chk("R1", rd_data, 11'h23C, "second entry");
    pop_sw();
    chk("R1", rd_data, 11'h47E, "third entry");
    pop_sw();
    chk("R1", level, 0, "level after drain");
    pop_sw();
    chk("R1", level, 0, "pop on empty ignored");
    clr(6'h3e);
  endtask

  task automatic t_overrun();
    for (int i = 0; i < 16; i++) push(8'(i + 8'h10));
    chk("R2", irq_raw[4], 0, "no overrun at full");
    push(8'hEE);
    chk("R2", level, 16, "level after overrun");
    chk("R2", irq_raw[4], 1, "overrun status");
    for (int i = 0; i < 15; i++) pop_sw();
    chk("R2", rd_data[7:0], 8'h1F, "last kept byte, dropped byte absent");
    pop_sw();
    clr(6'h10);
    chk("R7", irq_raw[4], 0, "overrun cleared by write one");
  endtask

  task automatic t_trigger();
    for (int s = 0; s < 4; s++) begin
      int t;
      t = (s == 0) ? 2 : (s == 1) ? 4 : (s == 2) ? 8 : 12;
      cfg_trig = 2'(s);
      for (int i = 0; i < t - 1; i++) push(8'(i));
      chk("R5", irq_raw[0], 0, $sformatf("below trigger sel %0d", s));
      push(8'h55);
      chk("R5", irq_raw[0], 1, $sformatf("at trigger sel %0d", s));
      drain_all();
    end
    cfg_trig = 1;
  endtask

  task automatic t_dma_req();
    push(8'h01);
    chk("R6", dma_sreq, 0, "single request with DMA off");
    @(negedge clk); dma_en = 1; #1;
    chk("R6", {dma_sreq, dma_breq}, 2'b10, "single only below trigger");
    push(8'h02); push(8'h03); push(8'h04);
    chk("R6", {dma_sreq, dma_breq}, 2'b11, "burst at trigger");
    @(negedge clk); dma_en = 0; #1;
    chk("R6", {dma_sreq, dma_breq}, 2'b00, "requests dropped when disabled");
    drain_all();
  endtask

  task automatic t_timeout();
    tick16 = 1;
    push(8'h61);
    repeat (500) @(negedge clk);
    chk("R3", irq_raw[1], 0, "timeout not before 32 bits");
    repeat (20) @(negedge clk);
    chk("R3", irq_raw[1], 1, "timeout after 32 bits");
    chk("R8", irq, 1, "timeout reaches line with DMA off");
    pop_sw();
    chk("R4", irq_raw[1], 0, "timeout cleared by drain");
    push(8'h62);
    repeat (300) @(negedge clk);
    push(8'h63);
    repeat (300) @(negedge clk);
    chk("R4", irq_raw[1], 0, "window restarted by push");
    repeat (220) @(negedge clk);
    chk("R4", irq_raw[1], 1, "timeout after restart");
    clr(6'h02);
    chk("R4", irq_raw[1], 0, "timeout cleared by write one");
    drain_all();
    cfg_fast = 1;
    push(8'h64);
    repeat (600) @(negedge clk);
    chk("R3", irq_raw[1], 0, "fast window not expired at 600");
    repeat (440) @(negedge clk);
    chk("R3", irq_raw[1], 1, "fast window expired");
    tick16 = 0; cfg_fast = 0;
    drain_all();
    clr(6'h02);
  endtask

  task automatic t_suppress();
    @(negedge clk); dma_en = 1;
    for (int i = 0; i < 4; i++) push(8'(i));
    chk("R8", irq_raw[0], 1, "level status recorded under DMA");
    chk("R8", irq_masked[0], 0, "level status blocked under DMA");
    chk("R8", irq, 0, "line quiet under DMA");
    push(8'h99, 1, 0, 0);
    chk("R9", irq_raw[2], 1, "framing status under DMA");
    chk("R9", irq, 1, "framing reaches line under DMA");
    chk("R11", dma_sreq, 1, "requests continue without stop-on-error");
    clr(6'h04);
    @(negedge clk); dma_en = 0;
    drain_all();
  endtask

  task automatic t_done();
    @(negedge clk); dma_en = 1; dma_done = 1;
    @(negedge clk); dma_done = 0;
    chk("R10", irq_raw[5], 1, "done status");
    chk("R10", irq, 1, "done raises line");
    clr(6'h20);
    chk("R7", irq_raw[5], 0, "done cleared by write one");
    chk("R10", irq, 0, "line low after clear");
    @(negedge clk); dma_en = 0;
  endtask

  task automatic t_errhold();
    @(negedge clk); dma_en = 1; dma_on_err = 1;
    push(8'h11);
    chk("R11", dma_sreq, 1, "request before error");
    push(8'h22, 0, 1, 0);
    chk("R11", dma_sreq, 0, "request stopped after parity error");
    clr(6'h08);
    chk("R11", dma_sreq, 1, "request resumed after clear");
    @(negedge clk); dma_en = 0; dma_on_err = 0;
    drain_all();
  endtask

  task automatic t_remaining();
    @(negedge clk); dma_len = 5; dma_len_load = 1;
    @(negedge clk); dma_len_load = 0;
    chk("R12", dma_remaining, 5, "loaded count");
    for (int i = 0; i < 8; i++) push(8'(i));
    for (int i = 0; i < 3; i++) pop_dma();
    chk("R12", dma_remaining, 2, "count after three pops");
    for (int i = 0; i < 3; i++) pop_dma();
    chk("R12", dma_remaining, 0, "count holds at zero");
    drain_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_order();
    t_overrun();
    t_trigger();
    t_dma_req();
    t_timeout();
    t_suppress();
    t_done();
    t_errhold();
    t_remaining();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule